// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the status byte of a serial nonvolatile memory and rules on every write that reaches it. A host-facing command decoder hands it one-cycle pulses: set the write latch, clear the write latch, write the status byte, or write the array at a given address. The block answers each write request in the same cycle on `wr_permit`. When it grants a request, it starts an internal write cycle of `WRITE_CYCLES` clocks.

Three things guard the writes. The first is a write latch that must be armed beforehand. The second is a two-bit region field that fences off none, the upper quarter, the upper half or all of the array. The third is a status lock: if the lock-enable bit is set and the active-low `lock_n` pin is driven low, the nonvolatile status bits cannot be rewritten. The rest of the device keeps working while the lock holds. The status byte is always available for readback on `status`.

A granted status write takes effect only when its cycle ends. The latch clears when every write cycle completes. A refused request is dropped without notice and changes nothing.

Top module: `sr_guard`

## Requirements
- R1: The region field status[3:2] protects array addresses as follows: 00 none; 01 addresses 0x1800 and up (upper two address bits 11); 10 addresses 0x1000 and up; 11 every address. An array write to a protected address is refused (`wr_permit` low).
- R2: Any status or array write that arrives while the write latch (status[1]) is 0 is refused.
- R3: When the lock-enable bit status[7] is 1 and `lock_n` is 0, a status write is refused. Array writes are still decided only by R1 and R2.
- R4: When status[7] is 0, `lock_n` has no effect, and a status write with the latch set is accepted even while the pin is low.
- R5: When `lock_n` is 1, a status write with the latch set is accepted whatever the value of status[7].
- R6: Once a status write has been accepted, later changes on `lock_n` do not alter its outcome.
- R7: The write latch is 0 after reset. It is cleared by a latch-clear command and at the end of every completed write cycle. It is set by a latch-set command.
- R8: A refused write starts no cycle (status[0] stays 0) and leaves the latch value unchanged.
- R9: An accepted write holds status[0] and `busy` at 1 for exactly `WRITE_CYCLES` clocks. During that time every command is ignored and `wr_permit` stays 0.
- R10: The status byte layout is bit 7 lock-enable, bits 6:4 zero, bits 3:2 region, bit 1 latch, bit 0 write in progress. With default parameters it reads 0x00 after reset.
- R11: An accepted status write copies bits 7, 3 and 2 of `stat_wdata` into the status byte at the end of the cycle. Before then those bits keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on default) |
| cmd_latch_set | input | 1 | Arm the write latch |
| cmd_latch_clr | input | 1 | Disarm the write latch |
| cmd_stat_wr | input | 1 | Status write request |
| stat_wdata | input | 8 | Status byte to write |
| cmd_arr_wr | input | 1 | Array write request |
| arr_addr | input | ADDR_W | Target address of the array write |
| lock_n | input | 1 | Active-low status lock pin |
| wr_permit | output | 1 | Current request accepted |
| busy | output | 1 | Internal write cycle running |
| status | output | 8 | Status byte for readback |

## Verification
The checker observes every cycle. On each clock it confirms four things: a granted array write never falls inside the region selected by status[3:2]; a status write is never granted under an active lock; nothing is granted while a cycle runs; and the nonvolatile bits change only at the end of a cycle. It also confirms that a cycle begins only with the latch armed and always ends with the latch cleared. Some behaviour is visible only in the bench's scenarios. These include the exact address boundaries of each region, the fact that a pin drop during a running cycle leaves the result unchanged, the cycle length, and the fact that a refused request leaves the latch armed.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W = 13,
  parameter int WRITE_CYCLES = 16,
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_latch_set,
  input  logic              cmd_latch_clr,
  input  logic              cmd_stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              cmd_arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              lock_n,
  output logic              wr_permit,
  output logic              busy,
  output logic [7:0]        status
);
  localparam int CNT_W = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic             lock_en, wel, wip, pend_sr;
  logic [1:0]       bp;
  logic [2:0]       pend_nv;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       top2;
  logic             in_prot, sr_open;

  assign top2    = arr_addr[ADDR_W-1 -: 2];
  assign in_prot = (bp == 2'b11) | ((bp == 2'b10) & top2[1]) | ((bp == 2'b01) & (&top2));
  assign sr_open = lock_n | ~lock_en;

  assign wr_permit = ~wip & wel & ((cmd_arr_wr & ~in_prot) | (cmd_stat_wr & sr_open));
  assign busy      = wip;
  assign status    = {lock_en, 3'b000, bp, wel, wip};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_en <= NV_INIT[7];
      bp      <= NV_INIT[3:2];
      wel     <= 1'b0;
      wip     <= 1'b0;
      pend_sr <= 1'b0;
      pend_nv <= 3'b000;
      cnt     <= '0;
    end else if (wip) begin
      if (cnt == '0) begin
        wip <= 1'b0;
        wel <= 1'b0;
        if (pend_sr) {lock_en, bp} <= pend_nv;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (wr_permit) begin
      wip     <= 1'b1;
      cnt     <= CNT_LOAD;
      pend_sr <= cmd_stat_wr;
      pend_nv <= {stat_wdata[7], stat_wdata[3:2]};
    end else if (cmd_latch_clr) begin
      wel <= 1'b0;
    end else if (cmd_latch_set) begin
      wel <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_stat_wr,
  input logic              cmd_arr_wr,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              lock_n,
  input logic              wr_permit,
  input logic              busy,
  input logic [7:0]        status
);
  localparam logic [ADDR_W-1:0] QTR_LO  = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_LO = ADDR_W'(1) << (ADDR_W - 1);

  logic fenced;
  always_comb begin
    case (status[3:2])
      2'd0:    fenced = 1'b0;
      2'd1:    fenced = (arr_addr >= QTR_LO);
      2'd2:    fenced = (arr_addr >= HALF_LO);
      default: fenced = 1'b1;
    endcase
  end

  p_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_permit && cmd_arr_wr) |-> !fenced);
  p_latch_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(status[1]));
  p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stat_wr && status[7] && !lock_n) |-> !wr_permit);
  p_latch_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status[1]);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_permit);
  p_nv_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({status[7], status[3:2]}));
  p_layout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6:4] == 3'b000) && (status[0] == busy));
endmodule

bind sr_guard sr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stat_wr(cmd_stat_wr), .cmd_arr_wr(cmd_arr_wr),
  .arr_addr(arr_addr), .lock_n(lock_n), .wr_permit(wr_permit), .busy(busy),
  .status(status)
);

// File: tb/sr_guard_bench.sv
module sr_guard_bench;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_set = 0, c_clr = 0, c_sw = 0, c_aw = 0, lock_n = 1;
  logic [7:0] wdata = 0;
  logic [12:0] addr = 0;
  logic permit, busy;
  logic [7:0] status;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sr_guard #(.ADDR_W(13), .WRITE_CYCLES(W)) u_sr_guard (
    .clk(clk), .rst_n(rst_n), .cmd_latch_set(c_set), .cmd_latch_clr(c_clr),
    .cmd_stat_wr(c_sw), .stat_wdata(wdata), .cmd_arr_wr(c_aw), .arr_addr(addr),
    .lock_n(lock_n), .wr_permit(permit), .busy(busy), .status(status));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // op: 0 set latch, 1 clear latch, 2 status write, 3 array write
  task automatic issue(input int op, input logic [12:0] a, input logic [7:0] d, output logic perm);
    c_set = (op == 0); c_clr = (op == 1); c_sw = (op == 2); c_aw = (op == 3);
    addr = a; wdata = d;
    #2 perm = permit;
    @(negedge clk);
    c_set = 0; c_clr = 0; c_sw = 0; c_aw = 0;
  endtask

  task automatic wait_cycle();
    repeat (W) @(negedge clk);
  endtask

  task automatic load_status(input logic [7:0] d);
    logic p;
    issue(0, 0, 0, p);
    issue(2, 0, d, p);
    chk("R5 load", p, 1);
    wait_cycle();
  endtask

  task automatic t_reset();
    chk("R10 reset status", status, 8'h00);
    chk("R7 reset latch", status[1], 0);
  endtask

  task automatic t_latch();
    logic p;
    issue(0, 0, 0, p);
    chk("R7 latch set", status, 8'h02);
    issue(1, 0, 0, p);
    chk("R7 latch clear", status, 8'h00);
  endtask

  task automatic t_no_latch();
    logic p;
    issue(3, 13'h0010, 0, p);
    chk("R2 array without latch", p, 0);
    issue(2, 0, 8'h8C, p);
    chk("R2 status without latch", p, 0);
    chk("R8 no cycle", status, 8'h00);
  endtask

  task automatic t_cycle();
    logic p;
    issue(0, 0, 0, p);
    issue(3, 13'h0004, 0, p);
    chk("R9 accepted", p, 1);
    chk("R9 busy start", status, 8'h03);
    repeat (W - 1) @(negedge clk);
    chk("R9 busy last", busy, 1);
    @(negedge clk);
    chk("R9 busy end", busy, 0);
    chk("R7 latch cleared at end", status, 8'h00);
  endtask

  task automatic t_regions();
    logic p;
    logic [12:0] probes [6] = '{13'h0000, 13'h0FFF, 13'h1000, 13'h17FF, 13'h1800, 13'h1FFF};
    for (int r = 0; r < 4; r++) begin
      load_status({4'b0, r[1:0], 2'b00});
      chk("R11 region loaded", status, {4'b0, r[1:0], 2'b00});
      for (int i = 0; i < 6; i++) begin
        logic prot;
        prot = (r == 3) || (r == 2 && probes[i] >= 13'h1000) || (r == 1 && probes[i] >= 13'h1800);
        issue(0, 0, 0, p);
        issue(3, probes[i], 0, p);
        chk("R1 region decision", p, !prot);
        if (p) begin
          wait_cycle();
        end else begin
          chk("R8 refused keeps latch", status, {4'b0, r[1:0], 2'b10});
          issue(1, 0, 0, p);
        end
      end
    end
    load_status(8'h00);
  endtask

  task automatic t_lock();
    logic p;
    load_status(8'h80);
    chk("R11 lock bit set", status, 8'h80);
    lock_n = 0;
    issue(0, 0, 0, p);
    issue(2, 0, 8'h00, p);
    chk("R3 status locked", p, 0);
    chk("R8 locked keeps latch", status, 8'h82);
    issue(3, 13'h1FFF, 0, p);
    chk("R3 array still allowed", p, 1);
    wait_cycle();
    lock_n = 1;
    issue(0, 0, 0, p);
    issue(2, 0, 8'h84, p);
    chk("R5 pin high allows", p, 1);
    wait_cycle();
    chk("R5 status updated", status, 8'h84);
    load_status(8'h00);
    lock_n = 0;
    issue(0, 0, 0, p);
    issue(2, 0, 8'h08, p);
    chk("R4 pin ignored when disabled", p, 1);
    wait_cycle();
    chk("R4 status updated", status, 8'h08);
    lock_n = 1;
    load_status(8'h00);
  endtask

  task automatic t_pin_drop();
    logic p;
    load_status(8'h80);
    issue(0, 0, 0, p);
    issue(2, 0, 8'h0C, p);
    chk("R6 accepted", p, 1);
    lock_n = 0;
    @(negedge clk);
    chk("R11 old bits during cycle", status, 8'h83);
    issue(1, 0, 0, p);
    chk("R9 clear ignored while busy", status[1], 1);
    issue(3, 0, 0, p);
    chk("R9 write ignored while busy", p, 0);
    repeat (W - 3) @(negedge clk);
    chk("R6 result kept after pin drop", status, 8'h0C);
    lock_n = 1;
    load_status(8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_no_latch();
    t_cycle();
    t_regions();
    t_lock();
    t_pin_drop();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule